// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures an intermediate-frequency signal by counting its rising edges during a gate of fixed length. A free-running timebase supplies one tick per millisecond slice. Software raises a start control to begin. The block then waits for a settling interval so the IF path can reach its bias level. Next it opens the gate for the selected number of milliseconds, counts, and freezes the result. A done flag marks completion, and an output multiplexer elsewhere can use it as a completion indicator. The frequency is the count divided by the gate time. For example, 0x53980 edges in a 32 ms gate means 10.7 MHz.

The start control is level-sensitive. A 0-to-1 change begins a measurement. While the control stays at 1 the frozen result stays readable. Returning it to 0 clears the count and the flag. An inhibit input stops the counter entirely. The IF input is asynchronous. It is brought into the clock domain through a synchroniser and an edge detector, so the IF frequency must stay below a quarter of the system clock.

Top module: `if_gate_counter`

## Requirements
- R1: The result is `CNT_W` bits wide (20 by default) and counts each synchronised rising edge of `if_i` only while the gate is open. Outside the gate the result does not change.
- R2: `gate_sel_i` picks the gate length in timebase milliseconds (`TICKS_PER_MS` ticks each): 2'b00 gives 4, 2'b01 gives 8, 2'b10 gives 32 and 2'b11 gives 64. The gate opens on the cycle after the last wait tick and closes on the cycle after its own last tick.
- R3: Before the gate opens, the block counts 4 ms of ticks for codes 2'b00 and 2'b01, and 8 ms of ticks for 2'b10 and 2'b11. Because the tick phase is unknown, this is 3 to 4 ms or 7 to 8 ms of real time.
- R4: A measurement begins only on a clock where `start_i` is 1 and was 0 on the previous clock. If `start_i` is already high when the block becomes free, nothing starts.
- R5: While `start_i` is 0, the result is zero and `done_o` is low from the next clock onward. This is also the state after reset.
- R6: `done_o` is low from the start through the whole gate. It goes high on the cycle after the gate closes, and the result then holds until `start_i` falls.
- R7: While `inhibit_i` is 1, any measurement is aborted, the result is zero, `done_o` is low and start edges are ignored.
- R8: The result saturates at all ones and never wraps.
- R9: `if_i` passes through a two-stage synchroniser and an edge detector. An IF high phase of any length counts as exactly one edge.
- R10: The gate code is captured when the measurement starts. Later changes to `gate_sel_i` do not change that measurement's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inhibit_i | input | 1 | Stops and clears the counter |
| start_i | input | 1 | Level start/clear control |
| gate_sel_i | input | 2 | Gate length code |
| if_i | input | 1 | Asynchronous IF signal |
| tick_i | input | 1 | Timebase tick, one clock wide |
| count_o | output | CNT_W (20) | Edge count |
| done_o | output | 1 | Measurement complete |

## Verification
A phase counter that is off by one shifts the cycle where `done_o` rises by a full tick period. Because the model is compared every clock, that shows up within ten clocks of the expected close. A gate that is open in the wrong phase, or an edge detector that counts levels, makes `count_o` drift during the wait or after done. That drift is visible on the first IF edge that lands there. A clear that is missing on a start drop or an inhibit leaves a non-zero result one cycle later.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_GATE = 2'd2,
    PH_DONE = 2'd3
  } phase_t;

  // gate length in milliseconds for each select code
  function automatic int gate_ms(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4;
      2'b01:   return 8;
      2'b10:   return 32;
      default: return 64;
    endcase
  endfunction

  // settling wait in milliseconds: short gates wait 4, long gates wait 8
  function automatic int wait_ms(input logic [1:0] sel);
    return sel[1] ? 8 : 4;
  endfunction
endpackage

// File: rtl/ifc_edge_sync.sv
module ifc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  // R9: a detected edge is a single-cycle pulse
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ifc_gate_timer.sv
module ifc_gate_timer
  import ifc_pkg::*;
#(
  parameter int TICKS_PER_MS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inhibit_i,
  input  logic       start_i,
  input  logic [1:0] gate_sel_i,
  input  logic       tick_i,
  output logic       gating_o,
  output logic       clear_o,
  output logic       done_o
);
  localparam int MAX_TICKS = 64 * TICKS_PER_MS;
  localparam int TW        = $clog2(MAX_TICKS + 1);

  phase_t          ph_q, ph_n;
  logic [TW-1:0]   t_q, t_n;
  logic [1:0]      sel_q, sel_n;
  logic            start_q;
  logic            start_rise;
  logic            abort;
  logic [TW-1:0]   wait_len;
  logic [TW-1:0]   gate_len;

  assign start_rise = start_i & ~start_q;
  assign abort      = inhibit_i | ~start_i;
  assign wait_len   = TW'(wait_ms(sel_q) * TICKS_PER_MS);
  assign gate_len   = TW'(gate_ms(sel_q) * TICKS_PER_MS);

  always_comb begin
    ph_n  = ph_q;
    t_n   = t_q;
    sel_n = sel_q;
    if (abort) begin
      ph_n = PH_IDLE;
      t_n  = '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (start_rise) begin
            ph_n  = PH_WAIT;
            t_n   = '0;
            sel_n = gate_sel_i;
          end
        end
        PH_WAIT: begin
          if (tick_i) begin
            if (t_q == wait_len - TW'(1)) begin
              ph_n = PH_GATE;
              t_n  = '0;
            end else begin
              t_n = t_q + TW'(1);
            end
          end
        end
        PH_GATE: begin
          if (tick_i) begin
            if (t_q == gate_len - TW'(1)) begin
              ph_n = PH_DONE;
              t_n  = '0;
            end else begin
              t_n = t_q + TW'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      t_q     <= '0;
      sel_q   <= 2'b00;
      start_q <= 1'b0;
    end else begin
      ph_q    <= ph_n;
      t_q     <= t_n;
      sel_q   <= sel_n;
      start_q <= start_i;
    end
  end

  assign gating_o = (ph_q == PH_GATE);
  assign clear_o  = abort | (ph_q == PH_IDLE);
  assign done_o   = (ph_q == PH_DONE);

  // R3: the wait counter never passes its programmed length
  assert_wait_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_WAIT) |-> (t_q < wait_len));
  // R6: completion is reached only from an open gate
  assert_done_from_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(ph_q) == PH_GATE));
  // R5, R7: an abort returns to idle on the next clock
  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (ph_q == PH_IDLE));
  // R10: the captured code is stable while a measurement runs
  assert_sel_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE) && !abort |=> $stable(sel_q));
endmodule

// File: rtl/ifc_event_counter.sv
module ifc_event_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             ev_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             inc_ok;

  assign inc_ok = en_i & ev_i & (cnt_q != CNT_MAX);

  always_comb begin
    cnt_n = cnt_q;
    if (clr_i)       cnt_n = '0;
    else if (inc_ok) cnt_n = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign count_o = cnt_q;

  // R1: no change without a gated event
  assert_hold_outside_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i && !(en_i && ev_i) |=> $stable(count_o));
  // R8: all ones is sticky until cleared
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == CNT_MAX) && !clr_i |=> (count_o == CNT_MAX));
  // R5: a clear empties the result
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_o == '0));
endmodule

// File: rtl/if_gate_counter.sv
module if_gate_counter #(
  parameter int CNT_W        = 20,
  parameter int TICKS_PER_MS = 1,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inhibit_i,
  input  logic             start_i,
  input  logic [1:0]       gate_sel_i,
  input  logic             if_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o
);
  logic if_rise;
  logic gating;
  logic clear;

  ifc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (if_i),
    .rise_o  (if_rise)
  );

  ifc_gate_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .inhibit_i  (inhibit_i),
    .start_i    (start_i),
    .gate_sel_i (gate_sel_i),
    .tick_i     (tick_i),
    .gating_o   (gating),
    .clear_o    (clear),
    .done_o     (done_o)
  );

  ifc_event_counter #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clear),
    .en_i    (gating),
    .ev_i    (if_rise),
    .count_o (count_o)
  );

  // R7: inhibit leaves an empty, incomplete result
  assert_inhibit_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i |=> (count_o == '0) && !done_o);
  // R5: a low start drops completion
  assert_start_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);
  // R6: once done, the result is frozen while start stays high
  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && start_i && !inhibit_i |=> $stable(count_o));
endmodule

// File: tb/if_gate_counter_bench.sv
module if_gate_counter_bench;
  localparam int CW      = 8;
  localparam int TPM     = 1;
  localparam int TDIV    = 10;
  localparam int MAXV    = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          inhibit_i;
  logic          start_i;
  logic [1:0]    gate_sel_i;
  logic          if_i;
  logic          tick_i;
  logic [CW-1:0] count_o;
  logic          done_o;

  int n_vec  = 0;
  int n_fail = 0;
  string cur_req = "R5 reset";

  always #4 clk = ~clk;

  if_gate_counter #(.CNT_W(CW), .TICKS_PER_MS(TPM), .SYNC_STAGES(2)) u_if_gate_counter (
    .clk(clk), .rst_n(rst_n), .inhibit_i(inhibit_i), .start_i(start_i),
    .gate_sel_i(gate_sel_i), .if_i(if_i), .tick_i(tick_i),
    .count_o(count_o), .done_o(done_o)
  );

  // timebase and IF stimulus generators
  int tdiv = 0;
  int if_half = 0;
  int if_ph = 0;
  logic if_hold = 1'b0;
  always @(negedge clk) begin
    tick_i <= (tdiv == TDIV - 1);
    tdiv = (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    if (if_half == 0) begin
      if_i <= if_hold;
    end else begin
      if_ph = if_ph + 1;
      if (if_ph >= if_half) begin
        if_ph = 0;
        if_i <= ~if_i;
      end
    end
  end

  // behavioural reference model
  int m_ph, m_t, m_sel, m_cnt;
  bit m_s1, m_s2, m_s3, m_sq;
  function automatic int wl(int s); return (s >= 2) ? 8 * TPM : 4 * TPM; endfunction
  function automatic int gl(int s);
    int r;
    case (s) 0: r = 4; 1: r = 8; 2: r = 32; default: r = 64; endcase
    return r * TPM;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_t = 0; m_sel = 0; m_cnt = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_sq = 0;
    end else begin
      bit e, rz;
      e = m_s2 && !m_s3;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = if_i;
      rz = start_i && !m_sq;
      m_sq = start_i;
      if (inhibit_i || !start_i) begin
        m_ph = 0; m_t = 0; m_cnt = 0;
      end else begin
        case (m_ph)
          0: begin
            m_cnt = 0;
            if (rz) begin m_ph = 1; m_t = 0; m_sel = gate_sel_i; end
          end
          1: if (tick_i) begin
            if (m_t == wl(m_sel) - 1) begin m_ph = 2; m_t = 0; end
            else m_t = m_t + 1;
          end
          2: begin
            if (e && m_cnt < MAXV) m_cnt = m_cnt + 1;
            if (tick_i) begin
              if (m_t == gl(m_sel) - 1) begin m_ph = 3; m_t = 0; end
              else m_t = m_t + 1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_vec++;
      if (count_o !== CW'(m_cnt) || done_o !== (m_ph == 3)) begin
        n_fail++;
        $display("FAIL %s: count=%0d done=%0b expected count=%0d done=%0b",
                 cur_req, count_o, done_o, m_cnt, (m_ph == 3));
      end
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic wait_done(int limit);
    for (int i = 0; i < limit; i++) begin
      if (m_ph == 3) break;
      @(negedge clk);
    end
  endtask

  task automatic measure(int sel, int half);
    if_half = half;
    gate_sel_i = 2'(sel);
    @(negedge clk); start_i = 1'b1;
    wait_done(2000);
    cyc(15);
    start_i = 1'b0;
    cyc(4);
  endtask

  initial begin
    rst_n = 1'b0; inhibit_i = 1'b0; start_i = 1'b0; gate_sel_i = 2'b00;
    cyc(3);
    n_vec++;
    if (count_o !== '0 || done_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R5 reset: count=%0d done=%0b expected count=0 done=0", count_o, done_o);
    end
    rst_n = 1'b1;
    cyc(5);

    cur_req = "R1 R2 R3 R6 sel00"; measure(0, 1);
    cur_req = "R1 R2 R3 R6 sel01"; measure(1, 2);
    cur_req = "R1 R2 R3 R6 sel10"; measure(2, 3);
    cur_req = "R1 R2 R3 R6 sel11"; measure(3, 5);

    // R9: long IF high phases count once each
    cur_req = "R9 slow IF"; measure(0, 13);

    // R10: code changed mid measurement
    cur_req = "R10 sel change";
    if_half = 2; gate_sel_i = 2'b00;
    @(negedge clk); start_i = 1'b1;
    cyc(3); gate_sel_i = 2'b11;
    wait_done(2000); cyc(8); start_i = 1'b0; cyc(4);

    // R5: start dropped inside the gate
    cur_req = "R5 drop mid gate";
    gate_sel_i = 2'b01; @(negedge clk); start_i = 1'b1;
    cyc(90); start_i = 1'b0; cyc(6);

    // R7: inhibit inside the gate, then start high at release (R4)
    cur_req = "R7 inhibit mid gate";
    @(negedge clk); start_i = 1'b1;
    cyc(70); inhibit_i = 1'b1; cyc(30);
    cur_req = "R4 no edge after inhibit";
    inhibit_i = 1'b0; cyc(200);
    start_i = 1'b0; cyc(3);

    // R7: rising start during inhibit is ignored
    cur_req = "R7 start under inhibit";
    inhibit_i = 1'b1; cyc(2); start_i = 1'b1; cyc(20);
    inhibit_i = 1'b0; cyc(100); start_i = 1'b0; cyc(3);

    // R8: saturation with a fast IF and the longest gate
    cur_req = "R8 saturate"; measure(3, 1);

    // R1: IF idle produces zero
    cur_req = "R1 idle IF"; if_hold = 1'b0; measure(1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule